// File: doc/BRIEF.md
# Password-Gated Clock Control Register Bank

This block is the software-facing register bank of a clock manager with five PLLs. Each PLL owns seven 32-bit words: a manager word carrying the analog-reset bit, a control word with the power-down bit and the integer multiplier and post-divider fields, a fractional multiplier word, and four analog settings words. Software changes a word only by writing it with a fixed key in the top byte. Any other write is dropped without a trace. The key byte never reaches storage.

A single status word at offset zero is not stored. Each time it is read, it is assembled from the current control state of every PLL and reports which PLLs count as locked. Beside the bus, the block drives per-PLL outputs for downstream clock logic: the lock condition, an output-enable, the post-divider, and the effective integer and fractional multipliers, doubled when the PLL's prescaler bit is set. It also drives a one-cycle update strobe after every accepted write to one of that PLL's words.

The bus accepts one access per cycle (`bus_ready` stays high). A read returns its data one cycle after the handshake.

Top module: `clkctl_regbank`

## Requirements
- R1: A write changes a register only when bits 31:24 of the write data equal 0x5A; any other value leaves every register unchanged and raises no update strobe.
- R2: An accepted write stores the data with bits 31:24 forced to zero, so reading it back returns zero in that byte.
- R3: Only accesses with `bus_size` equal to 4 and `bus_addr[1:0]` equal to 0 are valid; any other read returns 0 and any other write is ignored.
- R4: PLL p (0..4) owns the words at byte 0x040 + 0x20*p plus 0x00 (manager), 0x04 (control), 0x08 (fractional), 0x0C, 0x10, 0x14 and 0x18 (analog 0..3); offset +0x1C and every other offset in the 0x2000-byte window except 0x000 reads 0 and ignores writes.
- R5: Reading offset 0x000 returns the lock word: bit 8+p is 1 when PLL p is locked, and all other bits are 0. PLL p is locked when control bit 16 (power-down) and manager bit 8 (analog reset) are both 0. Writes to 0x000 have no effect.
- R6: `pll_en[p]` is 1 exactly when PLL p is locked and its post-divider (control bits 14:12, also on `pll_pdiv`) is non-zero.
- R7: `pll_ndiv` carries control bits 9:0 and `pll_frac` carries fractional bits 19:0, each one bit wider than the field. When analog-1 bit 14 (prescaler) is set, both outputs carry the field shifted left by one.
- R8: An accepted write to any word of PLL p makes `pll_upd[p]` high for the one cycle after the write handshake, in the same cycle that the new value is visible; the strobe of every other PLL stays low.
- R9: Every read handshake, including an invalid one, gives `rsp_valid` high for exactly the next cycle with its data on `rsp_rdata`; writes give no response.
- R10: After reset all stored words are zero (so every PLL reads as locked and disabled), and `rsp_valid` and `pll_upd` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset in the window |
| bus_size | input | 3 | Access width in bytes |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pll_locked | output | 5 | Lock condition per PLL |
| pll_en | output | 5 | Output enable per PLL |
| pll_upd | output | 5 | One-cycle update strobe per PLL |
| pll_pdiv | output | 15 | Post-divider, 3 bits per PLL |
| pll_ndiv | output | 55 | Effective integer multiplier, 11 bits per PLL |
| pll_frac | output | 105 | Effective fractional multiplier, 21 bits per PLL |

## Verification
The bench sends writes with wrong keys (0xA5, 0x5B and random bytes), which would corrupt stored words or fire strobes if the key were compared on the wrong bits or not at all. It also sends accepted writes whose top byte reads back as anything but zero, which exposes a missing key clear. The lock word is read after the power-down and analog-reset bits are toggled and after a write aimed at offset 0x000; a stored or stale lock word would give a mismatch. The remaining stimulus covers misaligned and narrow accesses, the reserved slot and far offsets, a zero post-divider on a locked PLL, and the prescaler doubling. Under that stimulus a wrong decode would alias into a PLL word, and an enable that ignores the divider would stay high.

// File: rtl/clkctl_pkg.sv
// Package: shared constants for the clock control register bank.
// Assumes a 32-bit word and a fixed per-PLL group of eight word slots.
package clkctl_pkg;

    localparam int WORD_W       = 32;
    localparam int KEY_LSB      = 24;
    localparam int KEY_W        = 8;
    localparam logic [KEY_W-1:0] KEY_VALUE = 8'h5A;
    localparam logic [WORD_W-1:0] KEY_MASK = 32'hFF00_0000;

    // Field positions inside the per-PLL words
    localparam int NDIV_LSB     = 0;
    localparam int NDIV_W       = 10;
    localparam int PDIV_LSB     = 12;
    localparam int PDIV_W       = 3;
    localparam int PWRDN_BIT    = 16;
    localparam int ARST_BIT     = 8;
    localparam int FRAC_LSB     = 0;
    localparam int FRAC_W       = 20;
    localparam int PRESCALE_BIT = 14;

    // Word layout of the window
    localparam int LOCK_WORD    = 0;
    localparam int LOCK_SHIFT   = 8;
    localparam int GROUP_BASE   = 16;
    localparam int GROUP_WORDS  = 8;
    localparam int SLOT_W       = 3;
    localparam int NUM_ANA      = 4;
    localparam int ACCESS_BYTES = 4;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_MGR  = 3'd0,
        SLOT_CTRL = 3'd1,
        SLOT_FRAC = 3'd2,
        SLOT_ANA0 = 3'd3,
        SLOT_ANA1 = 3'd4,
        SLOT_ANA2 = 3'd5,
        SLOT_ANA3 = 3'd6,
        SLOT_RSVD = 3'd7
    } slot_e;

endpackage

// File: rtl/clkctl_decode.sv
// Module: address decoder.
// Splits a byte offset into validity, the lock-word hit, the PLL group hit,
// the PLL index and the slot. Assumes GROUP_BASE is a multiple of GROUP_WORDS.
module clkctl_decode
    import clkctl_pkg::*;
#(
    parameter int NUM_PLL = 5,
    parameter int ADDR_W  = 13,
    parameter int IDX_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output logic              access_ok,
    output logic              hit_lock,
    output logic              hit_group,
    output logic [IDX_W-1:0]  pll_idx,
    output logic [SLOT_W-1:0] slot
);

    localparam int WORDS_W = ADDR_W - 2;
    localparam logic [WORDS_W-1:0] GRP_LO   = WORDS_W'(GROUP_BASE);
    localparam logic [WORDS_W-1:0] GRP_HI   = WORDS_W'(GROUP_BASE + NUM_PLL * GROUP_WORDS);
    localparam logic [WORDS_W-1:0] LOCK_IDX = WORDS_W'(LOCK_WORD);

    logic [WORDS_W-1:0] word;
    logic [WORDS_W-1:0] grp_off;

    // Purpose: derive word index and offset inside the PLL group area
    always_comb begin
        word      = addr[ADDR_W-1:2];
        grp_off   = word - GRP_LO;
        slot      = grp_off[SLOT_W-1:0];
        pll_idx   = IDX_W'(grp_off >> SLOT_W);
        access_ok = (size == 3'(ACCESS_BYTES)) && (addr[1:0] == 2'b00);
        hit_lock  = access_ok && (word == LOCK_IDX);
        hit_group = access_ok && (word >= GRP_LO) && (word < GRP_HI)
                    && (slot != SLOT_RSVD);
    end

endmodule

// File: rtl/clkctl_pll_slice.sv
// Module: storage and derived outputs of one PLL.
// Holds the manager, control, fractional and four analog words, and raises a
// one-cycle strobe after each write. Assumes wr_slot is never the reserved slot
// while wr_en is high.
module clkctl_pll_slice
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_data,
    output logic              locked,
    output logic              enable,
    output logic              upd,
    output logic [PDIV_W-1:0] pdiv,
    output logic [NDIV_W:0]   ndiv_eff,
    output logic [FRAC_W:0]   frac_eff
);

    logic [WORD_W-1:0] mgr_q;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] frac_q;
    logic [WORD_W-1:0] ana_q [NUM_ANA];
    logic              upd_q;
    logic              prescale;
    logic [NDIV_W-1:0] ndiv_raw;
    logic [FRAC_W-1:0] frac_raw;

    // Purpose: store the manager, control and fractional words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgr_q  <= '0;
            ctrl_q <= '0;
            frac_q <= '0;
        end else if (wr_en) begin
            if (wr_slot == SLOT_MGR)  mgr_q  <= wr_data;
            if (wr_slot == SLOT_CTRL) ctrl_q <= wr_data;
            if (wr_slot == SLOT_FRAC) frac_q <= wr_data;
        end
    end

    // Purpose: store the analog words, one register per slot
    for (genvar a = 0; a < NUM_ANA; a++) begin : g_ana
        always_ff @(posedge clk) begin
            if (!rst_n)
                ana_q[a] <= '0;
            else if (wr_en && (wr_slot == SLOT_W'(int'(SLOT_ANA0) + a)))
                ana_q[a] <= wr_data;
        end
    end

    // Purpose: one-cycle strobe following an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= wr_en;
    end

    // Purpose: select the word addressed by a read
    always_comb begin
        case (rd_slot)
            SLOT_MGR:  rd_data = mgr_q;
            SLOT_CTRL: rd_data = ctrl_q;
            SLOT_FRAC: rd_data = frac_q;
            SLOT_ANA0: rd_data = ana_q[0];
            SLOT_ANA1: rd_data = ana_q[1];
            SLOT_ANA2: rd_data = ana_q[2];
            SLOT_ANA3: rd_data = ana_q[3];
            default:   rd_data = '0;
        endcase
    end

    // Purpose: lock, enable and effective multiplier from the stored fields
    always_comb begin
        locked   = !ctrl_q[PWRDN_BIT] && !mgr_q[ARST_BIT];
        pdiv     = ctrl_q[PDIV_LSB +: PDIV_W];
        enable   = locked && (pdiv != '0);
        prescale = ana_q[1][PRESCALE_BIT];
        ndiv_raw = ctrl_q[NDIV_LSB +: NDIV_W];
        frac_raw = frac_q[FRAC_LSB +: FRAC_W];
        ndiv_eff = prescale ? {ndiv_raw, 1'b0} : {1'b0, ndiv_raw};
        frac_eff = prescale ? {frac_raw, 1'b0} : {1'b0, frac_raw};
    end

    assign upd = upd_q;

endmodule

// File: rtl/clkctl_regbank.sv
// Module: top of the password-gated clock control register bank.
// Accepts one access per cycle, gates writes on the key byte, assembles the
// lock word on each read and returns read data one cycle later.
// Assumes NUM_PLL * GROUP_WORDS + GROUP_BASE words fit in the window.
module clkctl_regbank
    import clkctl_pkg::*;
#(
    parameter int NUM_PLL = 5,
    parameter int ADDR_W  = 13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_valid,
    output logic                        bus_ready,
    input  logic                        bus_write,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [2:0]                  bus_size,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic                        rsp_valid,
    output logic [WORD_W-1:0]           rsp_rdata,
    output logic [NUM_PLL-1:0]          pll_locked,
    output logic [NUM_PLL-1:0]          pll_en,
    output logic [NUM_PLL-1:0]          pll_upd,
    output logic [NUM_PLL*PDIV_W-1:0]   pll_pdiv,
    output logic [NUM_PLL*(NDIV_W+1)-1:0] pll_ndiv,
    output logic [NUM_PLL*(FRAC_W+1)-1:0] pll_frac
);

    localparam int IDX_W  = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;
    localparam int NOUT_W = NDIV_W + 1;
    localparam int FOUT_W = FRAC_W + 1;

    logic              access_ok;
    logic              hit_lock;
    logic              hit_group;
    logic [IDX_W-1:0]  pll_idx;
    logic [SLOT_W-1:0] slot;
    logic              key_ok;
    logic              wr_accept;
    logic              rd_accept;
    logic [WORD_W-1:0] wr_clean;
    logic [WORD_W-1:0] lock_word;
    logic [WORD_W-1:0] rd_value;
    logic [WORD_W-1:0] slice_rd [NUM_PLL];
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_data_q;

    assign bus_ready = 1'b1;

    clkctl_decode #(
        .NUM_PLL (NUM_PLL),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr      (bus_addr),
        .size      (bus_size),
        .access_ok (access_ok),
        .hit_lock  (hit_lock),
        .hit_group (hit_group),
        .pll_idx   (pll_idx),
        .slot      (slot)
    );

    // Purpose: qualify the handshake and strip the key byte
    always_comb begin
        key_ok    = (bus_wdata[KEY_LSB +: KEY_W] == KEY_VALUE);
        wr_accept = bus_valid && bus_ready && bus_write && hit_group && key_ok;
        rd_accept = bus_valid && bus_ready && !bus_write;
        wr_clean  = bus_wdata & ~KEY_MASK;
    end

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        logic [NOUT_W-1:0] s_ndiv;
        logic [FOUT_W-1:0] s_frac;
        logic [PDIV_W-1:0] s_pdiv;

        clkctl_pll_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_accept && (pll_idx == IDX_W'(p))),
            .wr_slot  (slot),
            .wr_data  (wr_clean),
            .rd_slot  (slot),
            .rd_data  (slice_rd[p]),
            .locked   (pll_locked[p]),
            .enable   (pll_en[p]),
            .upd      (pll_upd[p]),
            .pdiv     (s_pdiv),
            .ndiv_eff (s_ndiv),
            .frac_eff (s_frac)
        );

        assign pll_pdiv[p*PDIV_W +: PDIV_W] = s_pdiv;
        assign pll_ndiv[p*NOUT_W +: NOUT_W] = s_ndiv;
        assign pll_frac[p*FOUT_W +: FOUT_W] = s_frac;
    end

    // Purpose: assemble the live lock word and pick the read source
    always_comb begin
        lock_word = WORD_W'(pll_locked) << LOCK_SHIFT;
        rd_value  = '0;
        if (hit_lock) begin
            rd_value = lock_word;
        end else if (hit_group) begin
            for (int p = 0; p < NUM_PLL; p++) begin
                if (pll_idx == IDX_W'(p)) rd_value = slice_rd[p];
            end
        end
    end

    // Purpose: one-cycle read response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= rd_accept;
            if (rd_accept) rsp_data_q <= rd_value;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_data_q;

endmodule

// File: rtl/clkctl_regbank_chk.sv
// Module: property checker for clkctl_regbank, attached through bind.
// Observes ports only.
module clkctl_regbank_chk
    import clkctl_pkg::*;
#(
    parameter int NUM_PLL = 5,
    parameter int ADDR_W  = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [2:0]          bus_size,
    input logic [WORD_W-1:0]   bus_wdata,
    input logic                rsp_valid,
    input logic [WORD_W-1:0]   rsp_rdata,
    input logic [NUM_PLL-1:0]  pll_locked,
    input logic [NUM_PLL-1:0]  pll_en,
    input logic [NUM_PLL-1:0]  pll_upd
);

    p_bad_key_no_upd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && (bus_wdata[KEY_LSB +: KEY_W] != KEY_VALUE))
        |=> (pll_upd == '0));

    p_bad_access_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && ((bus_size != 3'(ACCESS_BYTES)) || (bus_addr[1:0] != 2'b00)))
        |=> (rsp_rdata == '0));

    p_lock_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == '0) && (bus_size == 3'(ACCESS_BYTES)))
        |=> (rsp_rdata == (WORD_W'($past(pll_locked)) << LOCK_SHIFT)));

    p_en_needs_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pll_en & ~pll_locked) == '0));

    p_upd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pll_upd));

    p_upd_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_upd != '0) |-> $past(bus_valid && bus_write));

    p_rsp_follows_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rsp_valid);

    p_no_rsp_otherwise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !rsp_valid);

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && (pll_upd == '0) && (pll_en == '0)));

endmodule

bind clkctl_regbank clkctl_regbank_chk #(
    .NUM_PLL (NUM_PLL),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .pll_locked (pll_locked),
    .pll_en     (pll_en),
    .pll_upd    (pll_upd)
);

// File: tb/test_clkctl_regbank.sv
`timescale 1ns/1ps
// Bench: scoreboard for clkctl_regbank. Drivers push expected read data,
// a monitor pops and compares on each response.
module test_clkctl_regbank;

    localparam int NP = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_ready;
    logic         bus_write = 1'b0;
    logic [12:0]  bus_addr = '0;
    logic [2:0]   bus_size = 3'd4;
    logic [31:0]  bus_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [4:0]   pll_locked;
    logic [4:0]   pll_en;
    logic [4:0]   pll_upd;
    logic [14:0]  pll_pdiv;
    logic [54:0]  pll_ndiv;
    logic [104:0] pll_frac;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NP][7];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    clkctl_regbank i_clkctl_regbank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pll_locked(pll_locked), .pll_en(pll_en), .pll_upd(pll_upd),
        .pll_pdiv(pll_pdiv), .pll_ndiv(pll_ndiv), .pll_frac(pll_frac)
    );

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic mlock(input int p);
        return !model[p][1][16] && !model[p][0][8];
    endfunction

    // Expected read value from R3, R4, R5
    function automatic logic [31:0] exp_read(input logic [12:0] a, input logic [2:0] sz);
        int w;
        logic [31:0] r;
        r = '0;
        if (sz != 3'd4 || a[1:0] != 2'b00) return '0;
        w = int'(a >> 2);
        if (w == 0) begin
            for (int p = 0; p < NP; p++) r[8+p] = mlock(p);
            return r;
        end
        if (w >= 16 && w < 56 && (w % 8) != 7) return model[(w-16)/8][w%8];
        return '0;
    endfunction

    // Monitor: compare each response with the head of the queue (R9)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected response", 128'(rsp_rdata), 128'(0));
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata == e, t, 128'(rsp_rdata), 128'(e));
            end
        end
    end

    task automatic rd(input logic [12:0] a, input logic [2:0] sz, input string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        exp_q.push_back(exp_read(a, sz));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Check derived outputs of every PLL against the model (R6, R7)
    task automatic chk_outputs();
        for (int p = 0; p < NP; p++) begin
            logic [9:0]  n;
            logic [19:0] f;
            logic        pre;
            logic [2:0]  pd;
            n   = model[p][1][9:0];
            f   = model[p][2][19:0];
            pre = model[p][4][14];
            pd  = model[p][1][14:12];
            chk(pll_locked[p] == mlock(p), "R5 pll_locked", 128'(pll_locked[p]), 128'(mlock(p)));
            chk(pll_en[p] == (mlock(p) && pd != 0), "R6 pll_en", 128'(pll_en[p]), 128'(mlock(p) && pd != 0));
            chk(pll_pdiv[p*3 +: 3] == pd, "R6 pll_pdiv", 128'(pll_pdiv[p*3 +: 3]), 128'(pd));
            chk(pll_ndiv[p*11 +: 11] == (pre ? {n, 1'b0} : {1'b0, n}), "R7 pll_ndiv",
                128'(pll_ndiv[p*11 +: 11]), 128'(pre ? {n, 1'b0} : {1'b0, n}));
            chk(pll_frac[p*21 +: 21] == (pre ? {f, 1'b0} : {1'b0, f}), "R7 pll_frac",
                128'(pll_frac[p*21 +: 21]), 128'(pre ? {f, 1'b0} : {1'b0, f}));
        end
    endtask

    // Write with model update and strobe check (R1, R2, R3, R4, R8)
    task automatic wr(input logic [12:0] a, input logic [2:0] sz, input logic [31:0] d);
        int w;
        logic [4:0] eupd;
        eupd = '0;
        w = int'(a >> 2);
        if (sz == 3'd4 && a[1:0] == 2'b00 && d[31:24] == 8'h5A &&
            w >= 16 && w < 56 && (w % 8) != 7) begin
            model[(w-16)/8][w%8] = d & 32'h00FF_FFFF;
            eupd[(w-16)/8] = 1'b1;
        end
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(pll_upd == eupd, "R8 update strobe", 128'(pll_upd), 128'(eupd));
    endtask

    task automatic rd_all(input string tag);
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 8; s++)
                rd(13'(64 + p*32 + s*4), 3'd4, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 128'(0), 128'(1));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 7; s++) model[p][s] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(rsp_valid == 1'b0, "R10 rsp_valid", 128'(rsp_valid), 128'(0));
        chk(pll_upd == '0, "R10 pll_upd", 128'(pll_upd), 128'(0));
        chk(pll_en == '0, "R10 pll_en", 128'(pll_en), 128'(0));
        chk(pll_locked == 5'h1F, "R10 pll_locked", 128'(pll_locked), 128'(5'h1F));
        rst_n = 1'b1;
        @(negedge clk);
        rd_all("R10 register after reset");
        rd(13'h000, 3'd4, "R5 lock word after reset");
        chk_outputs();

        // R2 R6: accepted write to PLL0 control, key byte cleared
        wr(13'h044, 3'd4, 32'h5A00_3064);
        @(negedge clk);
        chk(pll_upd == '0, "R8 strobe lasts one cycle", 128'(pll_upd), 128'(0));
        rd(13'h044, 3'd4, "R2 key byte cleared");
        chk_outputs();

        // R1: wrong keys to PLL1 control
        wr(13'h064, 3'd4, 32'hA500_3064);
        wr(13'h064, 3'd4, 32'h5B00_7001);
        rd(13'h064, 3'd4, "R1 wrong key ignored");
        chk_outputs();

        // R5: power-down on PLL2, analog reset on PLL3
        wr(13'h084, 3'd4, 32'h5A01_1010);
        wr(13'h0A0, 3'd4, 32'h5A00_0100);
        wr(13'h0A4, 3'd4, 32'h5A00_2002);
        rd(13'h000, 3'd4, "R5 lock word with PLL2 and PLL3 unlocked");
        chk_outputs();

        // R7: prescaler doubling on PLL4
        wr(13'h0C4, 3'd4, 32'h5A00_1155);
        wr(13'h0C8, 3'd4, 32'h5A0A_BCDE);
        chk_outputs();
        wr(13'h0D0, 3'd4, 32'h5A00_4000);
        wr(13'h0CC, 3'd4, 32'h5A12_3456);
        chk_outputs();
        rd(13'h0D0, 3'd4, "R7 analog word readback");

        // R3: misaligned and narrow accesses
        rd(13'h046, 3'd4, "R3 misaligned read");
        rd(13'h044, 3'd2, "R3 narrow read");
        wr(13'h045, 3'd4, 32'h5A00_0777);
        wr(13'h044, 3'd1, 32'h5A00_0777);
        rd(13'h044, 3'd4, "R3 invalid writes ignored");

        // R4 R5: lock word write, reserved slot, far offsets
        wr(13'h000, 3'd4, 32'h5A00_0000);
        rd(13'h000, 3'd4, "R5 lock word write ignored");
        wr(13'h05C, 3'd4, 32'h5A00_FFFF);
        rd(13'h05C, 3'd4, "R4 reserved slot");
        wr(13'h1000, 3'd4, 32'h5A00_ABCD);
        rd(13'h1000, 3'd4, "R4 unmapped offset");
        rd(13'h1FFC, 3'd4, "R4 last word of window");
        rd(13'h03C, 3'd4, "R4 word below PLL groups");
        rd(13'h0E0, 3'd4, "R4 word above PLL groups");
        rd_all("R4 no aliasing into PLL words");

        // R6: zero post-divider on a locked PLL
        wr(13'h044, 3'd4, 32'h5A00_0064);
        chk(pll_locked[0] && !pll_en[0], "R6 zero divider disables", 128'(pll_en[0]), 128'(0));
        chk_outputs();

        // R9: back-to-back reads
        rd(13'h040, 3'd4, "R9 back-to-back 1");
        rd(13'h044, 3'd4, "R9 back-to-back 2");
        rd(13'h000, 3'd4, "R9 back-to-back 3");

        // R1 R2 R8: pseudo-random writes with mixed keys
        lf = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            logic [12:0] a;
            logic [31:0] d;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            a = 13'(64 + (int'(lf[10:8]) % 5) * 32 + int'(lf[14:12]) * 4);
            d = {(lf[0] ? 8'h5A : lf[31:24]), lf[23:0] ^ {lf[7:0], lf[15:0]}};
            wr(a, 3'd4, d);
            if (i % 25 == 0) begin
                chk_outputs();
                rd(13'h000, 3'd4, "R5 lock word random");
            end
        end
        rd_all("R2 random readback");
        chk_outputs();

        // R10: reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < NP; p++)
            for (int s = 0; s < 7; s++) model[p][s] = '0;
        exp_q.delete();
        tag_q.delete();
        chk(pll_en == '0 && pll_locked == 5'h1F, "R10 second reset", 128'(pll_en), 128'(0));
        rd_all("R10 cleared after reset");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 missing responses", 128'(exp_q.size()), 128'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule